// File: doc/BRIEF.md
# Dual-Strobe Presettable Up/Down Counter

This block is a four-bit binary counter with two separate count strobes. A rising edge on the up strobe adds one and a rising edge on the down strobe subtracts one, so the strobe that moves decides the direction; there is no direction bit. The count wraps modulo 16 in both directions. A preset bus can be loaded through an active-low load input, and an active-high clear input zeroes the count. Clear wins over load.

Everything runs in one system clock domain. Both strobes are sampled on that clock, and their rising edges are found by comparing the current sample with the previous one. This adds one cycle between a strobe edge and the new count. Load and clear take effect on the next clock and do not wait for a strobe edge. While either is active, strobe edges are ignored. The edge detectors keep tracking the strobes during that time, so a strobe that rose under load or clear does not count once load or clear is released.

Two active-low terminal-count outputs are gated by the sampled strobe level. One is low at count 15 while the up strobe is low, and the other is low at count 0 while the down strobe is low. Each therefore forms a pulse whose rising end can drive the matching strobe of the next counter in a chain.

Top module: `updn_counter`

## Requirements
- R1: With the down strobe high, a 0-to-1 change of the up strobe raises `count` by one. The new value appears on the second rising clock edge after the strobe changes.
- R2: With the up strobe high, a 0-to-1 change of the down strobe lowers `count` by one, with the same two-edge latency.
- R3: A 1-to-0 change of either strobe leaves `count` unchanged.
- R4: A rising edge on one strobe leaves `count` unchanged while the other strobe is low. If both strobes rise in the same clock sample, `count` also holds.
- R5: While `load_n` is 0 and `clr` is 0, each clock edge copies `preset` into `count`, and strobe edges have no effect.
- R6: While `clr` is 1, each clock edge sets `count` to 0, whatever `load_n`, `preset` and the strobes are doing.
- R7: Counting is modulo 16. Up from 15 gives 0, and down from 0 gives 15.
- R8: `tc_up_n` is 0 exactly when `count` is 15 and the registered up-strobe sample is 0. It follows the strobe one clock edge after the strobe changes.
- R9: `tc_dn_n` is 0 exactly when `count` is 0 and the registered down-strobe sample is 0, with the same one-edge lag.
- R10: A strobe that rises while `load_n` is 0 or `clr` is 1, and then stays high, causes no count once load or clear is released.
- R11: The synchronous system reset `rst` sets `count` to 0 and treats both strobes as already high. With the strobes held high after reset, both terminal-count outputs are 1 and no count occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| clr | input | 1 | Active-high clear of the count |
| load_n | input | 1 | Active-low parallel load |
| preset | input | 4 | Value to load |
| up_stb | input | 1 | Count-up strobe; rising edge adds one |
| dn_stb | input | 1 | Count-down strobe; rising edge subtracts one |
| count | output | 4 | Current count |
| tc_up_n | output | 1 | Active-low overflow terminal count |
| tc_dn_n | output | 1 | Active-low underflow terminal count |

## Verification
The checker tests on every cycle that clear forces zero and that load copies the preset. It also checks that, without load or clear, the count moves by at most one step modulo 16, and that a low terminal-count output only ever appears at the matching count value. Only the bench's scenarios can show the rest. These cover the exact two-edge counting latency, the inhibit when the other strobe is low or rises at the same time, the missing count after a strobe rose during load or clear, and the timing of the terminal-count pulses. The bench loads every preset value and steps up and down from each one, checking wrap and the terminal-count outputs against values it works out by arithmetic.

// File: rtl/updn_cnt_pkg.sv
package updn_cnt_pkg;

    localparam int unsigned CNT_W   = 4;
    localparam int unsigned NUM_STB = 2;
    localparam int unsigned STB_UP  = 0;
    localparam int unsigned STB_DN  = 1;

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t CNT_MAX = {CNT_W{1'b1}};
    localparam cnt_t CNT_MIN = '0;

    typedef struct packed {
        logic cur;
        logic prev;
    } smp_t;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_INC,
        OP_DEC,
        OP_LOAD,
        OP_CLEAR
    } op_e;

    function automatic logic rose(input smp_t s);
        return s.cur & ~s.prev;
    endfunction

    function automatic logic steady_high(input smp_t s);
        return s.cur & s.prev;
    endfunction

endpackage

// File: rtl/strobe_sampler.sv
module strobe_sampler
    import updn_cnt_pkg::*;
#(
    parameter int unsigned N = NUM_STB
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     stb,
    output smp_t [N-1:0]     smp
);

    for (genvar i = 0; i < N; i++) begin : g_stb
        smp_t s_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                s_q <= '{cur: 1'b1, prev: 1'b1};
            end else begin
                s_q <= '{cur: stb[i], prev: s_q.cur};
            end
        end
        assign smp[i] = s_q;
    end

endmodule

// File: rtl/count_core.sv
module count_core
    import updn_cnt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic load_n,
    input  cnt_t preset,
    input  smp_t smp_up,
    input  smp_t smp_dn,
    output cnt_t count
);

    op_e  op;
    cnt_t cnt_q;

    always_comb begin
        if (clr) begin
            op = OP_CLEAR;
        end else if (!load_n) begin
            op = OP_LOAD;
        end else if (rose(smp_up) && steady_high(smp_dn)) begin
            op = OP_INC;
        end else if (rose(smp_dn) && steady_high(smp_up)) begin
            op = OP_DEC;
        end else begin
            op = OP_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_MIN;
        end else begin
            unique case (op)
                OP_CLEAR: cnt_q <= CNT_MIN;
                OP_LOAD:  cnt_q <= preset;
                OP_INC:   cnt_q <= cnt_q + cnt_t'(1);
                OP_DEC:   cnt_q <= cnt_q - cnt_t'(1);
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/tc_decode.sv
module tc_decode
    import updn_cnt_pkg::*;
(
    input  cnt_t count,
    input  logic up_lvl,
    input  logic dn_lvl,
    output logic tc_up_n,
    output logic tc_dn_n
);

    always_comb begin
        tc_up_n = ~((count == CNT_MAX) & ~up_lvl);
        tc_dn_n = ~((count == CNT_MIN) & ~dn_lvl);
    end

endmodule

// File: rtl/updn_counter.sv
module updn_counter
    import updn_cnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             load_n,
    input  logic [CNT_W-1:0] preset,
    input  logic             up_stb,
    input  logic             dn_stb,
    output logic [CNT_W-1:0] count,
    output logic             tc_up_n,
    output logic             tc_dn_n
);

    smp_t [NUM_STB-1:0] smp;
    cnt_t               cnt_w;
    logic [NUM_STB-1:0] stb_vec;

    always_comb begin
        stb_vec         = '0;
        stb_vec[STB_UP] = up_stb;
        stb_vec[STB_DN] = dn_stb;
    end

    strobe_sampler #(.N(NUM_STB)) u_sampler (
        .clk (clk),
        .rst (rst),
        .stb (stb_vec),
        .smp (smp)
    );

    count_core u_core (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .load_n (load_n),
        .preset (preset),
        .smp_up (smp[STB_UP]),
        .smp_dn (smp[STB_DN]),
        .count  (cnt_w)
    );

    tc_decode u_tc (
        .count   (cnt_w),
        .up_lvl  (smp[STB_UP].cur),
        .dn_lvl  (smp[STB_DN].cur),
        .tc_up_n (tc_up_n),
        .tc_dn_n (tc_dn_n)
    );

    assign count = cnt_w;

endmodule

// File: rtl/updn_counter_chk.sv
module updn_counter_chk
    import updn_cnt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             load_n,
    input logic [CNT_W-1:0] preset,
    input logic [CNT_W-1:0] count,
    input logic             tc_up_n,
    input logic             tc_dn_n
);

    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == CNT_MIN));

    p_load_r5: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load_n) |=> (count == $past(preset)));

    p_single_step_r7: assert property (@(posedge clk) disable iff (rst)
        (!clr && load_n) |=> ((count == $past(count))
                           || (count == cnt_t'($past(count) + cnt_t'(1)))
                           || (count == cnt_t'($past(count) - cnt_t'(1)))));

    p_tc_up_at_max_r8: assert property (@(posedge clk) disable iff (rst)
        !tc_up_n |-> (count == CNT_MAX));

    p_tc_dn_at_min_r9: assert property (@(posedge clk) disable iff (rst)
        !tc_dn_n |-> (count == CNT_MIN));

    p_tc_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
        $countones({~tc_up_n, ~tc_dn_n}) <= 1);

endmodule

bind updn_counter updn_counter_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .load_n  (load_n),
    .preset  (preset),
    .count   (count),
    .tc_up_n (tc_up_n),
    .tc_dn_n (tc_dn_n)
);

// File: tb/updn_counter_tb_top.sv
module updn_counter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst;
    logic       clr;
    logic       load_n;
    logic [3:0] preset;
    logic       up_stb;
    logic       dn_stb;
    logic [3:0] count;
    logic       tc_up_n;
    logic       tc_dn_n;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    updn_counter dut_i (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .load_n  (load_n),
        .preset  (preset),
        .up_stb  (up_stb),
        .dn_stb  (dn_stb),
        .count   (count),
        .tc_up_n (tc_up_n),
        .tc_dn_n (tc_dn_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_load(input int v);
        preset = 4'(v);
        load_n = 1'b0;
        step(1);
        load_n = 1'b1;
    endtask

    task automatic pulse_up();
        up_stb = 1'b0;
        step(2);
        up_stb = 1'b1;
        step(2);
    endtask

    task automatic pulse_dn();
        dn_stb = 1'b0;
        step(2);
        dn_stb = 1'b1;
        step(2);
    endtask

    initial begin
        rst = 1'b1; clr = 1'b0; load_n = 1'b1; preset = '0;
        up_stb = 1'b1; dn_stb = 1'b1;
        step(3);
        rst = 1'b0;
        step(3);
        // R11: reset state, no spurious count with strobes high
        chk("R11 count", int'(count), 0);
        chk("R11 tc_up_n", int'(tc_up_n), 1);
        chk("R11 tc_dn_n", int'(tc_dn_n), 1);

        // Sweep every preset: load, up, down (R1, R2, R5, R7)
        for (int p = 0; p < 16; p++) begin
            do_load(p);
            chk("R5 load", int'(count), p);
            pulse_up();
            chk("R1 R7 up", int'(count), (p + 1) % 16);
            pulse_dn();
            pulse_dn();
            chk("R2 R7 down", int'(count), (p + 15) % 16);
        end

        // R1 latency: after one edge the count has not yet moved
        do_load(5);
        up_stb = 1'b0; step(2);
        up_stb = 1'b1; step(1);
        chk("R1 latency before", int'(count), 5);
        step(1);
        chk("R1 latency after", int'(count), 6);

        // R3: falling edges do nothing
        up_stb = 1'b0; step(3);
        chk("R3 up fall", int'(count), 6);
        up_stb = 1'b1; step(2);
        dn_stb = 1'b0; step(3);
        chk("R3 dn fall", int'(count), 7);
        dn_stb = 1'b1; step(3);
        chk("R2 after fall", int'(count), 6);

        // R4: other strobe low inhibits
        do_load(9);
        dn_stb = 1'b0; up_stb = 1'b0; step(2);
        up_stb = 1'b1; step(3);
        chk("R4 up inhibited", int'(count), 9);
        up_stb = 1'b0; step(2);
        dn_stb = 1'b1; step(3);
        chk("R4 dn inhibited", int'(count), 9);
        // R4: both rise together
        dn_stb = 1'b0; step(2);
        up_stb = 1'b1; dn_stb = 1'b1; step(3);
        chk("R4 both rise", int'(count), 9);

        // R5: held load ignores strobe edges; R10: no count after release
        preset = 4'd3; load_n = 1'b0;
        up_stb = 1'b0; step(2);
        up_stb = 1'b1; step(3);
        chk("R5 load held", int'(count), 3);
        load_n = 1'b1; step(3);
        chk("R10 after load", int'(count), 3);

        // R6: clear over load; R10 after clear
        preset = 4'd12; load_n = 1'b0; clr = 1'b1;
        dn_stb = 1'b0; step(2);
        dn_stb = 1'b1; step(2);
        chk("R6 clear wins", int'(count), 0);
        clr = 1'b0; load_n = 1'b1; step(3);
        chk("R10 after clear", int'(count), 0);

        // R7 wrap explicit
        do_load(15); pulse_up();
        chk("R7 wrap up", int'(count), 0);
        pulse_dn();
        chk("R7 wrap down", int'(count), 15);

        // R8: tc_up_n pulse at 15
        do_load(15);
        chk("R8 idle high", int'(tc_up_n), 1);
        up_stb = 1'b0; step(1);
        chk("R8 low", int'(tc_up_n), 0);
        chk("R9 not at 15", int'(tc_dn_n), 1);
        up_stb = 1'b1; step(1);
        chk("R8 released", int'(tc_up_n), 1);
        chk("R8 count still 15", int'(count), 15);
        step(1);
        chk("R8 overflow", int'(count), 0);

        // R9: tc_dn_n pulse at 0
        chk("R9 idle high", int'(tc_dn_n), 1);
        dn_stb = 1'b0; step(1);
        chk("R9 low", int'(tc_dn_n), 0);
        chk("R8 not at 0", int'(tc_up_n), 1);
        dn_stb = 1'b1; step(2);
        chk("R9 released", int'(tc_dn_n), 1);
        chk("R9 underflow", int'(count), 15);

        // R9: down strobe low at count 7 keeps tc_dn_n high
        do_load(7);
        dn_stb = 1'b0; step(2);
        chk("R9 nonzero", int'(tc_dn_n), 1);
        dn_stb = 1'b1; step(2);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule